// File: doc/BRIEF.md
# Strap and Register Configuration Merger

This block turns two configuration sources into the effective per-port controls of a multi-port Ethernet transceiver. The first source is a set of strap pins whose levels are sampled while reset is held. The second is a set of management register bits, one copy per port. For each function the block combines the two sources by a fixed rule and drives one control line per port to the datapath blocks that use it.

Most functions are enabled when either the strap or the register bit asks for them. Autonegotiation works the other way: it runs only when a live pin and the register bit both ask for it. That pin is synchronized, and each rising edge on it produces a one-cycle restart strobe. A port can be put in fiber mode by its own strap or by its own register bit. Fiber mode overrides several settings whatever the registers hold: far-end fault signalling is on, MLT-3 coding is off, the scrambler is bypassed, autonegotiation is off, signal-detect is in use, and 10 Mbit/s operation is off.

Top module: `strap_cfg_merge`

## Requirements
- R1: While `rst_n` is low, every strap input (`strap_*`) is sampled on each rising clock edge. The value held on the last edge of reset is used until the next reset. Changes on strap inputs after reset has been released have no effect on any output.
- R2: `cfg_carint[p]` equals the captured carrier-integrity strap OR `reg_carint[p]`.
- R3: `cfg_scr_byp[p]` equals the captured bypass strap OR `reg_scr_byp[p]`, and is forced to 1 when port p is in fiber mode.
- R4: `cfg_lnk_chk[p]` equals the captured link-change-detect strap OR `reg_lnk_chk[p]`.
- R5: The blink request of a port is the captured blink strap OR `reg_led_blink[p]`, and it drives `cfg_led_blink[p]`. The stretch request is the captured stretch strap OR `reg_led_stretch[p]`. `cfg_led_stretch[p]` is high only when the stretch request is high and the blink request is low.
- R6: `cfg_an_en[p]` equals the synchronized `an_pin` level AND `reg_an_en[p]` AND NOT fiber mode. A change on `an_pin` reaches `cfg_an_en` after two rising clock edges.
- R7: When `an_pin` goes from 0 to 1, `cfg_an_restart[p]` goes high for exactly one cycle, starting on the third rising edge after the change. This happens on every port that is not in fiber mode. A falling edge, a held level, and reset produce no strobe.
- R8: `cfg_fiber[p]` equals the captured per-port fiber strap `strap_fiber[p]` OR `reg_fiber[p]`.
- R9: In fiber mode a port has `cfg_fef_en`=1, `cfg_mlt3_en`=0, `cfg_sigdet_en`=1 and `cfg_ten_en`=0. Outside fiber mode the same four outputs are 0, 1, 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while it is low |
| strap_carint | input | 1 | Carrier-integrity strap |
| strap_scr_byp | input | 1 | Scrambler-bypass strap |
| strap_lnk_chk | input | 1 | Link speed-change detect strap |
| strap_led_blink | input | 1 | Activity LED blink strap |
| strap_led_stretch | input | 1 | Activity LED stretch strap |
| strap_fiber | input | NPORTS | Per-port fiber-mode strap |
| an_pin | input | 1 | Asynchronous autonegotiation enable/restart pin |
| reg_carint | input | NPORTS | Carrier-integrity register bit per port |
| reg_scr_byp | input | NPORTS | Scrambler-bypass register bit per port |
| reg_lnk_chk | input | NPORTS | Link-change-detect register bit per port |
| reg_led_blink | input | NPORTS | LED blink register bit per port |
| reg_led_stretch | input | NPORTS | LED stretch register bit per port |
| reg_an_en | input | NPORTS | Autonegotiation enable register bit per port |
| reg_fiber | input | NPORTS | Fiber-mode register bit per port |
| cfg_carint | output | NPORTS | Effective carrier-integrity enable |
| cfg_scr_byp | output | NPORTS | Effective scrambler bypass |
| cfg_lnk_chk | output | NPORTS | Effective link-change detect enable |
| cfg_led_blink | output | NPORTS | Effective LED blink mode |
| cfg_led_stretch | output | NPORTS | Effective LED stretch mode |
| cfg_an_en | output | NPORTS | Effective autonegotiation enable |
| cfg_an_restart | output | NPORTS | One-cycle autonegotiation restart strobe |
| cfg_fiber | output | NPORTS | Effective fiber mode |
| cfg_fef_en | output | NPORTS | Far-end fault signalling enable |
| cfg_mlt3_en | output | NPORTS | MLT-3 coding enable |
| cfg_sigdet_en | output | NPORTS | Signal-detect input enable |
| cfg_ten_en | output | NPORTS | 10 Mbit/s operation enable |

## Verification
Random register words are applied to all ports together, and each output is compared with a model of the merge rules. Strap sets are drawn at random for each reset. The straps change value part way through reset and again after it, which separates a capture on the last reset edge from a capture on an earlier edge or a live pass-through. The autonegotiation pin gets a held-high level, a single-cycle pulse and a falling edge, with a mix of fiber and copper ports. This separates edge detection from level detection, shows that the strobe comes three edges after the pin change, and shows that fiber ports never receive the strobe. Running with the pin both low and high shows the AND rule of autonegotiation set against the OR rules of the other functions.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  // Straps shared by all ports, captured during reset
  typedef struct packed {
    logic carint;
    logic scr_byp;
    logic lnk_chk;
    logic blink;
    logic stretch;
  } glob_strap_t;

  localparam int GLOB_STRAP_W = $bits(glob_strap_t);

  // Effective per-port configuration
  typedef struct packed {
    logic carint;
    logic scr_byp;
    logic lnk_chk;
    logic led_blink;
    logic led_stretch;
    logic an_en;
    logic fiber;
    logic fef_en;
    logic mlt3_en;
    logic sigdet_en;
    logic ten_en;
  } port_cfg_t;

  // A function is on when either source asks for it
  function automatic logic either_src(input logic strap_bit, input logic reg_bit);
    return strap_bit | reg_bit;
  endfunction

  // Both sources must agree, and fiber mode vetoes
  function automatic logic both_src(input logic pin_lvl, input logic reg_bit, input logic veto);
    return pin_lvl & reg_bit & ~veto;
  endfunction

  // Blink takes priority over stretch; returns {blink, stretch}
  function automatic logic [1:0] led_pick(input logic blink_req, input logic stretch_req);
    return {blink_req, stretch_req & ~blink_req};
  endfunction

endpackage

// File: rtl/strap_cfg_capture.sv
module strap_cfg_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_in,
  output logic [WIDTH-1:0] held_o
);

  // Transparent sampling while reset is low; frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) held_o <= pins_in;
  end

endmodule

// File: rtl/strap_cfg_an_edge.sv
module strap_cfg_an_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic level_o,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $fatal(1, "SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], pin_async};
      prev_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign level_o = chain_q[SYNC_STAGES-1];
  assign rise_o  = chain_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/strap_cfg_port.sv
module strap_cfg_port
  import strap_cfg_pkg::*;
(
  input  glob_strap_t straps_i,
  input  logic        strap_fiber_i,
  input  logic        reg_carint_i,
  input  logic        reg_scr_byp_i,
  input  logic        reg_lnk_chk_i,
  input  logic        reg_blink_i,
  input  logic        reg_stretch_i,
  input  logic        reg_an_en_i,
  input  logic        reg_fiber_i,
  input  logic        an_level_i,
  output port_cfg_t   cfg_o
);

  logic       fiber_w;
  logic [1:0] led_w;

  assign fiber_w = either_src(strap_fiber_i, reg_fiber_i);
  assign led_w   = led_pick(either_src(straps_i.blink, reg_blink_i),
                            either_src(straps_i.stretch, reg_stretch_i));

  always_comb begin
    cfg_o             = '0;
    cfg_o.fiber       = fiber_w;
    cfg_o.carint      = either_src(straps_i.carint, reg_carint_i);
    cfg_o.lnk_chk     = either_src(straps_i.lnk_chk, reg_lnk_chk_i);
    cfg_o.led_blink   = led_w[1];
    cfg_o.led_stretch = led_w[0];
    // Fiber override wins over register control
    cfg_o.scr_byp     = fiber_w | either_src(straps_i.scr_byp, reg_scr_byp_i);
    cfg_o.an_en       = both_src(an_level_i, reg_an_en_i, fiber_w);
    cfg_o.fef_en      = fiber_w;
    cfg_o.mlt3_en     = ~fiber_w;
    cfg_o.sigdet_en   = fiber_w;
    cfg_o.ten_en      = ~fiber_w;
  end

endmodule

// File: rtl/strap_cfg_merge.sv
module strap_cfg_merge
  import strap_cfg_pkg::*;
#(
  parameter int NPORTS      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_carint,
  input  logic              strap_scr_byp,
  input  logic              strap_lnk_chk,
  input  logic              strap_led_blink,
  input  logic              strap_led_stretch,
  input  logic [NPORTS-1:0] strap_fiber,
  input  logic              an_pin,
  input  logic [NPORTS-1:0] reg_carint,
  input  logic [NPORTS-1:0] reg_scr_byp,
  input  logic [NPORTS-1:0] reg_lnk_chk,
  input  logic [NPORTS-1:0] reg_led_blink,
  input  logic [NPORTS-1:0] reg_led_stretch,
  input  logic [NPORTS-1:0] reg_an_en,
  input  logic [NPORTS-1:0] reg_fiber,
  output logic [NPORTS-1:0] cfg_carint,
  output logic [NPORTS-1:0] cfg_scr_byp,
  output logic [NPORTS-1:0] cfg_lnk_chk,
  output logic [NPORTS-1:0] cfg_led_blink,
  output logic [NPORTS-1:0] cfg_led_stretch,
  output logic [NPORTS-1:0] cfg_an_en,
  output logic [NPORTS-1:0] cfg_an_restart,
  output logic [NPORTS-1:0] cfg_fiber,
  output logic [NPORTS-1:0] cfg_fef_en,
  output logic [NPORTS-1:0] cfg_mlt3_en,
  output logic [NPORTS-1:0] cfg_sigdet_en,
  output logic [NPORTS-1:0] cfg_ten_en
);

  localparam int HELD_W = GLOB_STRAP_W + NPORTS;

  glob_strap_t              glob_pins_w;
  glob_strap_t              glob_held_w;
  logic [NPORTS-1:0]        fiber_held_w;
  logic [HELD_W-1:0]        straps_held;    // named for the checker
  logic                     an_level_w;
  logic                     an_rise_w;      // named for the checker
  logic [NPORTS-1:0]        restart_q;

  assign glob_pins_w = '{carint:  strap_carint,
                         scr_byp: strap_scr_byp,
                         lnk_chk: strap_lnk_chk,
                         blink:   strap_led_blink,
                         stretch: strap_led_stretch};

  strap_cfg_capture #(.WIDTH(HELD_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_in ({glob_pins_w, strap_fiber}),
    .held_o  (straps_held)
  );

  assign glob_held_w  = straps_held[HELD_W-1:NPORTS];
  assign fiber_held_w = straps_held[NPORTS-1:0];

  strap_cfg_an_edge #(.SYNC_STAGES(SYNC_STAGES)) u_an_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (an_pin),
    .level_o   (an_level_w),
    .rise_o    (an_rise_w)
  );

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      port_cfg_t cfg_w;

      strap_cfg_port u_port (
        .straps_i      (glob_held_w),
        .strap_fiber_i (fiber_held_w[p]),
        .reg_carint_i  (reg_carint[p]),
        .reg_scr_byp_i (reg_scr_byp[p]),
        .reg_lnk_chk_i (reg_lnk_chk[p]),
        .reg_blink_i   (reg_led_blink[p]),
        .reg_stretch_i (reg_led_stretch[p]),
        .reg_an_en_i   (reg_an_en[p]),
        .reg_fiber_i   (reg_fiber[p]),
        .an_level_i    (an_level_w),
        .cfg_o         (cfg_w)
      );

      assign cfg_carint[p]      = cfg_w.carint;
      assign cfg_scr_byp[p]     = cfg_w.scr_byp;
      assign cfg_lnk_chk[p]     = cfg_w.lnk_chk;
      assign cfg_led_blink[p]   = cfg_w.led_blink;
      assign cfg_led_stretch[p] = cfg_w.led_stretch;
      assign cfg_an_en[p]       = cfg_w.an_en;
      assign cfg_fiber[p]       = cfg_w.fiber;
      assign cfg_fef_en[p]      = cfg_w.fef_en;
      assign cfg_mlt3_en[p]     = cfg_w.mlt3_en;
      assign cfg_sigdet_en[p]   = cfg_w.sigdet_en;
      assign cfg_ten_en[p]      = cfg_w.ten_en;
    end
  endgenerate

  // Restart strobe: one cycle per synchronized rising edge, copper ports only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_q <= '0;
    else        restart_q <= {NPORTS{an_rise_w}} & ~cfg_fiber;
  end

  assign cfg_an_restart = restart_q;

endmodule

// File: rtl/strap_cfg_merge_chk.sv
module strap_cfg_merge_chk #(
  parameter int NPORTS = 8,
  parameter int HELD_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HELD_W-1:0] straps_held,
  input logic              an_rise_w,
  input logic [NPORTS-1:0] reg_an_en,
  input logic [NPORTS-1:0] cfg_scr_byp,
  input logic [NPORTS-1:0] cfg_led_blink,
  input logic [NPORTS-1:0] cfg_led_stretch,
  input logic [NPORTS-1:0] cfg_an_en,
  input logic [NPORTS-1:0] cfg_an_restart,
  input logic [NPORTS-1:0] cfg_fiber,
  input logic [NPORTS-1:0] cfg_fef_en,
  input logic [NPORTS-1:0] cfg_mlt3_en,
  input logic [NPORTS-1:0] cfg_sigdet_en,
  input logic [NPORTS-1:0] cfg_ten_en
);

  // R1: captured straps never move outside reset
  a_r1_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(straps_held));

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
      // R3: fiber forces scrambler bypass
      a_r3_fiber_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fiber[p] |-> cfg_scr_byp[p]);
      // R5: blink and stretch never both active
      a_r5_led_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_led_blink[p] |-> !cfg_led_stretch[p]);
      // R6: autoneg needs the register bit and copper mode
      a_r6_an_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_an_en[p] |-> (reg_an_en[p] && !cfg_fiber[p]));
      // R7: strobe follows a detected edge on a copper port and lasts one cycle
      a_r7_restart_src: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_an_restart[p] |-> ($past(an_rise_w) && !$past(cfg_fiber[p])));
      a_r7_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_an_restart[p] |=> !cfg_an_restart[p]);
      // R9: fiber override set, copper complement
      a_r9_fiber_force: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fiber[p] |-> (cfg_fef_en[p] && !cfg_mlt3_en[p] && cfg_sigdet_en[p] && !cfg_ten_en[p]));
      a_r9_copper_set: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fiber[p] |-> (!cfg_fef_en[p] && cfg_mlt3_en[p] && !cfg_sigdet_en[p] && cfg_ten_en[p]));
    end
  endgenerate

endmodule

bind strap_cfg_merge strap_cfg_merge_chk #(
  .NPORTS (NPORTS),
  .HELD_W (HELD_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .straps_held     (straps_held),
  .an_rise_w       (an_rise_w),
  .reg_an_en       (reg_an_en),
  .cfg_scr_byp     (cfg_scr_byp),
  .cfg_led_blink   (cfg_led_blink),
  .cfg_led_stretch (cfg_led_stretch),
  .cfg_an_en       (cfg_an_en),
  .cfg_an_restart  (cfg_an_restart),
  .cfg_fiber       (cfg_fiber),
  .cfg_fef_en      (cfg_fef_en),
  .cfg_mlt3_en     (cfg_mlt3_en),
  .cfg_sigdet_en   (cfg_sigdet_en),
  .cfg_ten_en      (cfg_ten_en)
);

// File: tb/strap_cfg_merge_bench.sv
module strap_cfg_merge_bench;

  localparam int  NP       = 8;
  localparam time CLK_HALF = 5ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_carint = 0, s_scr = 0, s_lnk = 0, s_blink = 0, s_stretch = 0;
  logic [NP-1:0] s_fiber = '0;
  logic an_pin = 1'b0;
  logic [NP-1:0] r_carint = '0, r_scr = '0, r_lnk = '0, r_blink = '0;
  logic [NP-1:0] r_stretch = '0, r_an = '0, r_fiber = '0;
  logic [NP-1:0] o_carint, o_scr, o_lnk, o_blink, o_stretch, o_an, o_rst;
  logic [NP-1:0] o_fiber, o_fef, o_mlt3, o_sigdet, o_ten;

  // bench model of captured straps and synchronized pin
  logic b_carint, b_scr, b_lnk, b_blink, b_stretch, an_lvl;
  logic [NP-1:0] b_fiber;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #CLK_HALF clk = ~clk;

  strap_cfg_merge #(.NPORTS(NP)) u_strap_cfg_merge (
    .clk(clk), .rst_n(rst_n),
    .strap_carint(s_carint), .strap_scr_byp(s_scr), .strap_lnk_chk(s_lnk),
    .strap_led_blink(s_blink), .strap_led_stretch(s_stretch), .strap_fiber(s_fiber),
    .an_pin(an_pin),
    .reg_carint(r_carint), .reg_scr_byp(r_scr), .reg_lnk_chk(r_lnk),
    .reg_led_blink(r_blink), .reg_led_stretch(r_stretch), .reg_an_en(r_an),
    .reg_fiber(r_fiber),
    .cfg_carint(o_carint), .cfg_scr_byp(o_scr), .cfg_lnk_chk(o_lnk),
    .cfg_led_blink(o_blink), .cfg_led_stretch(o_stretch), .cfg_an_en(o_an),
    .cfg_an_restart(o_rst), .cfg_fiber(o_fiber), .cfg_fef_en(o_fef),
    .cfg_mlt3_en(o_mlt3), .cfg_sigdet_en(o_sigdet), .cfg_ten_en(o_ten)
  );

  task automatic chk(input string req, input string what, input int p,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s port %0d: actual %b expected %b", req, what, p, act, exp);
    end
  endtask

  function automatic logic m_fiber(input int p);
    return b_fiber[p] | r_fiber[p];
  endfunction

  // Compare all outputs of all ports against the model
  task automatic check_all(input logic [NP-1:0] exp_rst);
    for (int p = 0; p < NP; p++) begin
      logic fb, bl;
      fb = m_fiber(p);
      bl = b_blink | r_blink[p];
      chk("R2", "carint",  p, o_carint[p], b_carint | r_carint[p]);
      chk("R3", "scr_byp", p, o_scr[p],    fb | b_scr | r_scr[p]);
      chk("R4", "lnk_chk", p, o_lnk[p],    b_lnk | r_lnk[p]);
      chk("R5", "blink",   p, o_blink[p],  bl);
      chk("R5", "stretch", p, o_stretch[p], (b_stretch | r_stretch[p]) & ~bl);
      chk("R6", "an_en",   p, o_an[p],     an_lvl & r_an[p] & ~fb);
      chk("R7", "restart", p, o_rst[p],    exp_rst[p]);
      chk("R8", "fiber",   p, o_fiber[p],  fb);
      chk("R9", "fef",     p, o_fef[p],    fb);
      chk("R9", "mlt3",    p, o_mlt3[p],   ~fb);
      chk("R9", "sigdet",  p, o_sigdet[p], fb);
      chk("R9", "ten",     p, o_ten[p],    ~fb);
    end
  endtask

  task automatic rand_regs();
    r_carint  = NP'($urandom);
    r_scr     = NP'($urandom);
    r_lnk     = NP'($urandom);
    r_blink   = NP'($urandom);
    r_stretch = NP'($urandom);
    r_an      = NP'($urandom);
    r_fiber   = NP'($urandom) & NP'($urandom);
  endtask

  task automatic rand_straps();
    s_carint = 1'($urandom); s_scr = 1'($urandom); s_lnk = 1'($urandom);
    s_blink = 1'($urandom); s_stretch = 1'($urandom); s_fiber = NP'($urandom);
  endtask

  // R1: straps move mid-reset, last value before release must stick
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; an_pin = 1'b0;
    {r_carint, r_scr, r_lnk, r_blink, r_stretch, r_an, r_fiber} = '0;
    rand_straps();
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) chk("R7", "restart in reset", p, o_rst[p], 1'b0);
    rand_straps();
    b_carint = s_carint; b_scr = s_scr; b_lnk = s_lnk;
    b_blink = s_blink; b_stretch = s_stretch; b_fiber = s_fiber;
    @(negedge clk);
    rst_n = 1'b1;
    an_lvl = 1'b0;
    check_all('0);
    // R1: strap pins after reset have no effect
    s_carint = ~b_carint; s_scr = ~b_scr; s_lnk = ~b_lnk;
    s_blink = ~b_blink; s_stretch = ~b_stretch; s_fiber = ~b_fiber;
    repeat (3) @(negedge clk);
    check_all('0);
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rand_regs();
      if (i % 7 == 3) rand_straps();   // R1: post-reset strap noise
      #1;
      check_all('0);
    end
  endtask

  // R6/R7: rising edge held high
  task automatic edge_test();
    logic [NP-1:0] cop;
    @(negedge clk);
    rand_regs();
    r_fiber = 8'b1010_0110;
    an_pin = 1'b1;
    for (int p = 0; p < NP; p++) cop[p] = ~m_fiber(p);
    @(negedge clk); check_all('0);      // one edge: level not through yet
    @(negedge clk); an_lvl = 1'b1; check_all('0);
    @(negedge clk); check_all(cop);     // R7: strobe on third edge
    @(negedge clk); check_all('0);      // R7: single cycle
    repeat (4) begin @(negedge clk); check_all('0); end
    an_pin = 1'b0;                       // R7: falling edge gives no strobe
    @(negedge clk); check_all('0);
    @(negedge clk); an_lvl = 1'b0; check_all('0);
    repeat (4) begin @(negedge clk); check_all('0); end
  endtask

  // R7: a one-cycle pulse on the pin
  task automatic pulse_test();
    logic [NP-1:0] cop;
    @(negedge clk);
    rand_regs();
    an_pin = 1'b1;
    for (int p = 0; p < NP; p++) cop[p] = ~m_fiber(p);
    @(negedge clk); an_pin = 1'b0;
    for (int p = 0; p < NP; p++) chk("R7", "pulse early", p, o_rst[p], 1'b0);
    @(negedge clk);
    for (int p = 0; p < NP; p++) chk("R7", "pulse early", p, o_rst[p], 1'b0);
    @(negedge clk);
    for (int p = 0; p < NP; p++) chk("R7", "pulse strobe", p, o_rst[p], cop[p]);
    @(negedge clk);
    for (int p = 0; p < NP; p++) chk("R7", "pulse end", p, o_rst[p], 1'b0);
    @(negedge clk);
    check_all('0);
  endtask

  initial begin
    void'($urandom(32'h1c3a_5e07));
    an_lvl = 1'b0;
    do_reset();
    rand_phase(60);
    edge_test();
    @(negedge clk); an_pin = 1'b1;
    repeat (3) @(negedge clk);
    an_lvl = 1'b1;
    rand_phase(60);                     // R6 with pin high
    @(negedge clk); an_pin = 1'b0;
    repeat (3) @(negedge clk);
    an_lvl = 1'b0;
    do_reset();
    rand_phase(40);
    pulse_test();
    edge_test();
    do_reset();
    // corner: all registers set, every port fiber via register
    @(negedge clk);
    {r_carint, r_scr, r_lnk, r_blink, r_stretch, r_an, r_fiber} = '1;
    #1; check_all('0);
    pulse_test();
    rand_phase(40);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule